// File: doc/BRIEF.md
# Serial ADC conversion sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a serial output. It drives the converter's active-low conversion-start line, watches the converter's busy flag, generates the serial clock for a fixed 16-clock readout, and collects the 12-bit straight-binary result. It then holds off for a programmed quiet interval before it launches the next conversion. While the run input is high it repeats this cycle without a break. When run drops, the cycle in progress finishes and the block goes idle.

Two orderings are supported. In the sequential ordering the block waits for busy to fall and then reads the new result. In the overlapped ordering it reads the previous result while the new conversion is still running, so the readout time drops out of the cycle. In both orderings a readout never spans a start edge. A start edge would reset the converter's output shift register in the middle of a frame. If busy stays high too long, a timeout flag is raised and the cycle moves on without a result. The pulse width, the quiet gap, the timeout bound and the serial clock divider are parameters counted in system-clock cycles.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During reset and directly after it, conv_start_n is high, sclk is low, result_vld is low and busy_timeout is low.
- R2: When run_en is high in the idle state, conv_start_n goes low for exactly PULSE_CYC system cycles and then returns high. The falling edge starts the conversion.
- R3: In the sequential ordering (overlap_mode low at cycle start), no sclk rising edge occurs while busy_in is high. The readout begins only after busy_in has been seen low.
- R4: Each readout is exactly 16 sclk pulses. sclk idles low, and each high phase and each low phase lasts SCLK_HALF system cycles.
- R5: sdata_in is sampled on each falling edge of sclk, most significant bit first. result takes the last 12 of the 16 sampled bits and discards the first 4.
- R6: result_vld is high for exactly one cycle per completed frame. It is raised the cycle after the sixteenth bit is sampled, and result holds its value until the next frame completes.
- R7: From the last sclk falling edge of a readout to the next conv_start_n falling edge, at least GAP_CYC system cycles pass.
- R8: conv_start_n never falls while a readout is partly done, and sclk stays low while conv_start_n is low.
- R9: In the overlapped ordering (overlap_mode high at cycle start), the readout starts right after the start pulse and returns the result of the previous conversion. The cycle is shorter than in the sequential ordering.
- R10: If busy_in stays high for BUSY_TMO_CYC cycles while the block waits for it, busy_timeout is set and no result_vld is produced for that cycle. The sequencer continues to the gap, and the flag clears at the next conversion start.
- R11: A conversion starts only when run_en was high on the cycle before. When run_en is low at the end of a gap, no further start pulse is issued. overlap_mode is sampled only at the start of each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Keep running conversion cycles while high |
| overlap_mode | input | 1 | 1 = read the previous result during the conversion, 0 = read after busy falls |
| busy_in | input | 1 | Converter busy flag, high while a conversion runs |
| sdata_in | input | 1 | Serial data from the converter |
| conv_start_n | output | 1 | Active-low conversion-start pulse |
| sclk | output | 1 | Generated serial clock |
| result | output | DATA_BITS | Last captured conversion result |
| result_vld | output | 1 | One-cycle strobe when result updates |
| busy_timeout | output | 1 | Busy did not fall within the bound in this cycle |

## Verification
The bench models a converter that loads a new word when busy falls and puts a bit on each sclk rise. It fills the four discard bits with a nonzero pattern, so a design that slices the wrong end of the frame returns a wrong value. Several checks target timing faults. A design that clocks data while busy is high in the sequential ordering is caught, and so is one whose next start cuts into the quiet gap or lands inside a frame, and one whose frame is not exactly sixteen pulses. In the overlapped ordering the bench expects the value from the preceding conversion, so a design that waits for busy there reads the fresh word and fails. A converter that never drops busy checks three things: the timeout flag must rise, no result may be produced, and the flag must clear at the next start. Dropping run_en must leave the start line quiet.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CONV = 3'd1,
      ST_WAIT = 3'd2,
      ST_READ = 3'd3,
      ST_GAP  = 3'd4
   } seq_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/adc_seq_sclkgen.sv
// Serial clock generator: idles low, equal high and low phases of HALF cycles.
module adc_seq_sclkgen #(
   parameter int HALF = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic sclk,
   output logic fall_stb
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [HW-1:0] hcnt_q;
   logic          sclk_q;
   logic          phase_end;

   assign phase_end = (hcnt_q == HW'(HALF - 1));
   assign fall_stb  = active && sclk_q && phase_end;
   assign sclk      = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hcnt_q <= '0;
         sclk_q <= 1'b0;
      end else if (!active) begin
         hcnt_q <= '0;
         sclk_q <= 1'b0;
      end else if (phase_end) begin
         hcnt_q <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !sclk_q); // R4

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !$past(active)) |-> !sclk_q); // R4

endmodule

// File: rtl/adc_seq_capture.sv
// Frame capture: shifts one bit per sample and keeps only the trailing data bits.
module adc_seq_capture #(
   parameter int FRAME_BITS = 16,
   parameter int DATA_BITS  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic                 sample,
   input  logic                 sdata,
   output logic                 frame_last,
   output logic [DATA_BITS-1:0] word,
   output logic                 word_vld
);
   localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

   logic [BW-1:0]        bit_q;
   logic [DATA_BITS-1:0] sr_q;
   logic [DATA_BITS-1:0] sr_d;
   logic [DATA_BITS-1:0] word_q;
   logic                 vld_q;

   generate
      if (DATA_BITS == 1) begin : g_single
         assign sr_d = sdata;
      end else begin : g_multi
         assign sr_d = {sr_q[DATA_BITS-2:0], sdata};
      end
   endgenerate

   assign frame_last = enable && sample && (bit_q == BW'(FRAME_BITS - 1));
   assign word       = word_q;
   assign word_vld   = vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q  <= '0;
         sr_q   <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= frame_last;
         if (!enable || frame_last) begin
            bit_q <= '0;
         end else if (sample) begin
            bit_q <= bit_q + 1'b1;
         end
         if (enable && sample) begin
            sr_q <= sr_d;
         end
         if (frame_last) begin
            word_q <= sr_d;
         end
      end
   end

   AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !word_vld); // R6

   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |-> $stable(word)); // R6

endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion sequencer top: start pulse, busy wait, 16-clock readout, quiet gap.
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int SCLK_HALF    = 5,
   parameter int PULSE_CYC    = 4,
   parameter int GAP_CYC      = 40,
   parameter int BUSY_TMO_CYC = 2000,
   parameter int FRAME_BITS   = 16,
   parameter int DATA_BITS    = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run_en,
   input  logic                 overlap_mode,
   input  logic                 busy_in,
   input  logic                 sdata_in,
   output logic                 conv_start_n,
   output logic                 sclk,
   output logic [DATA_BITS-1:0] result,
   output logic                 result_vld,
   output logic                 busy_timeout
);
   localparam int TMAX = max3(PULSE_CYC, GAP_CYC, BUSY_TMO_CYC);
   localparam int TW   = $clog2(TMAX + 1);
   localparam int QW   = $clog2(GAP_CYC + 1);

   generate
      if (SCLK_HALF < 1 || PULSE_CYC < 1 || GAP_CYC < 1 || BUSY_TMO_CYC < 2 ||
          DATA_BITS < 1 || DATA_BITS > FRAME_BITS) begin : g_bad_cfg
         $error("adc_seq_ctrl: illegal parameter set");
      end
   endgenerate

   seq_state_e    st_q, st_d;
   logic [TW-1:0] tcnt_q;
   logic          mode_q;
   logic          tmo_q;
   logic          tmo_set;
   logic          in_read;
   logic          fall_stb;
   logic          frame_last;
   logic          sclk_w;

   assign in_read = (st_q == ST_READ);

   adc_seq_sclkgen #(.HALF(SCLK_HALF)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (in_read),
      .sclk     (sclk_w),
      .fall_stb (fall_stb)
   );

   adc_seq_capture #(.FRAME_BITS(FRAME_BITS), .DATA_BITS(DATA_BITS)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (in_read),
      .sample     (fall_stb),
      .sdata      (sdata_in),
      .frame_last (frame_last),
      .word       (result),
      .word_vld   (result_vld)
   );

   always_comb begin
      st_d    = st_q;
      tmo_set = 1'b0;
      case (st_q)
         ST_IDLE: if (run_en) st_d = ST_CONV;
         ST_CONV: if (tcnt_q == TW'(PULSE_CYC - 1)) st_d = mode_q ? ST_READ : ST_WAIT;
         ST_WAIT: begin
            if (!busy_in) begin
               st_d = mode_q ? ST_GAP : ST_READ;
            end else if (tcnt_q == TW'(BUSY_TMO_CYC - 1)) begin
               st_d    = ST_GAP;
               tmo_set = 1'b1;
            end
         end
         ST_READ: if (frame_last) st_d = mode_q ? ST_WAIT : ST_GAP;
         ST_GAP:  if (tcnt_q == TW'(GAP_CYC - 1)) st_d = run_en ? ST_CONV : ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tcnt_q <= '0;
         mode_q <= 1'b0;
         tmo_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d != st_q || st_q == ST_READ || st_q == ST_IDLE) begin
            tcnt_q <= '0;
         end else begin
            tcnt_q <= tcnt_q + 1'b1;
         end
         if (st_d == ST_CONV && st_q != ST_CONV) begin
            mode_q <= overlap_mode;
            tmo_q  <= 1'b0;
         end else if (tmo_set) begin
            tmo_q <= 1'b1;
         end
      end
   end

   assign conv_start_n = (st_q != ST_CONV);
   assign sclk         = sclk_w;
   assign busy_timeout = tmo_q;

   // Quiet-time tracker for the gap check: cycles since sclk was last high.
   logic [QW-1:0] quiet_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_q <= QW'(GAP_CYC);
      end else if (sclk_w) begin
         quiet_q <= '0;
      end else if (quiet_q != QW'(GAP_CYC)) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_start_n) |-> (quiet_q == QW'(GAP_CYC))); // R7

   AST_NO_SCLK_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start_n |-> !sclk_w); // R8

   AST_SEQ_READ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && $rose(sclk_w)) |-> !busy_in); // R3

   AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_start_n) |=> !busy_timeout); // R10

   AST_START_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_start_n) |-> $past(run_en)); // R11

   AST_NO_VLD_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_timeout) |-> !result_vld); // R10

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF   = 5;
   localparam int PULSE  = 4;
   localparam int GAP    = 40;
   localparam int TMO    = 400;
   localparam int CONV   = 200;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_en = 1'b0;
   logic overlap_mode = 1'b0;
   logic busy_in;
   logic sdata_in;
   logic conv_start_n, sclk, result_vld, busy_timeout;
   logic [11:0] result;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_ctrl #(.SCLK_HALF(HALF), .PULSE_CYC(PULSE), .GAP_CYC(GAP),
                  .BUSY_TMO_CYC(TMO), .FRAME_BITS(16), .DATA_BITS(12)) uut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .overlap_mode(overlap_mode),
      .busy_in(busy_in), .sdata_in(sdata_in), .conv_start_n(conv_start_n),
      .sclk(sclk), .result(result), .result_vld(result_vld),
      .busy_timeout(busy_timeout));

   // Converter model and monitors, all evaluated at the falling clock edge.
   logic [11:0] next_val = 12'h000;
   logic        stuck = 1'b0;
   logic        busy_m = 1'b0;
   logic [15:0] word_m = 16'hA000;
   logic        sd_m = 1'b0;
   int          ccount = 0, kbit = 0;
   logic        sclk_p = 1'b0, conv_p = 1'b1;
   int cyc = 0, rises = 0, rises_at_vld = -1, straddle = 0, busy_rise_err = 0;
   int overlap_rise = 0, last_rise = 0, phase_err = 0, last_sfall = 0;
   int have_read = 0, min_gap = 1000000, last_cfall = -1, period = 0;
   int cfall_cyc = 0, pulse_w = 0, falls = 0, vld_count = 0;

   assign busy_in  = busy_m | stuck;
   assign sdata_in = sd_m;

   always @(negedge clk) begin
      cyc++;
      if (conv_p && !conv_start_n) begin
         busy_m = 1'b1; ccount = CONV; kbit = 0;
         if (rises != 0 && rises != 16) straddle++;
         rises = 0;
         if (have_read != 0 && (cyc - last_sfall) < min_gap) min_gap = cyc - last_sfall;
         have_read = 0;
         if (last_cfall >= 0) period = cyc - last_cfall;
         last_cfall = cyc; cfall_cyc = cyc; falls++;
      end else if (busy_m) begin
         if (ccount <= 1) begin busy_m = 1'b0; word_m = {4'hA, next_val}; end
         else ccount--;
      end
      if (!conv_p && conv_start_n) pulse_w = cyc - cfall_cyc;
      if (sclk && !sclk_p) begin
         sd_m = (kbit < 16) ? word_m[15 - kbit] : 1'b0;
         kbit++;
         if (rises > 0 && (cyc - last_rise) != 2*HALF) phase_err++;
         rises++; last_rise = cyc;
         if (busy_in && !overlap_mode) busy_rise_err++;
         if (busy_in && overlap_mode) overlap_rise++;
      end
      if (!sclk && sclk_p) begin
         if ((cyc - last_rise) != HALF) phase_err++;
         last_sfall = cyc; have_read = 1;
      end
      if (result_vld) begin rises_at_vld = rises; vld_count++; end
      sclk_p = sclk; conv_p = conv_start_n;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_vld(input int lim, output bit got);
      got = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk); #1;
         if (result_vld) begin got = 1; break; end
      end
   endtask

   task automatic wait_busy_low();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk); #1;
         if (!busy_in) break;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      #1;
      check(conv_start_n == 1'b1, "R1 conv_start_n", conv_start_n, 1);
      check(sclk == 1'b0, "R1 sclk", sclk, 0);
      check(result_vld == 1'b0, "R1 result_vld", result_vld, 0);
      check(busy_timeout == 1'b0, "R1 busy_timeout", busy_timeout, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      check(conv_start_n == 1'b1 && sclk == 1'b0, "R1 idle after reset", conv_start_n, 1);
   endtask

   task automatic t_sequential(output int per);
      bit got;
      int f0;
      overlap_mode = 1'b0;
      next_val = 12'hABC;
      run_en = 1'b1;
      wait_vld(2000, got);
      check(got, "R6 first frame strobe", got, 1);
      check(result == 12'hABC, "R5 result after busy", result, 12'hABC);
      check(rises_at_vld == 16, "R4 pulses per frame", rises_at_vld, 16);
      check(pulse_w == PULSE, "R2 start pulse width", pulse_w, PULSE);
      @(negedge clk); #1;
      check(result_vld == 1'b0, "R6 strobe one cycle", result_vld, 0);
      next_val = 12'h000;
      wait_vld(2000, got);
      check(got && result == 12'h000, "R5 zero word", result, 0);
      check(rises_at_vld == 16, "R4 pulses second frame", rises_at_vld, 16);
      per = period;
      run_en = 1'b0;
      f0 = falls;
      repeat (20) @(negedge clk); #1;
      check(result == 12'h000, "R6 result held", result, 0);
      repeat (600) @(negedge clk); #1;
      check(falls == f0 && conv_start_n, "R11 no start after run low", falls, f0);
      check(busy_rise_err == 0, "R3 no sclk while busy", busy_rise_err, 0);
      check(phase_err == 0, "R4 phase lengths", phase_err, 0);
      check(min_gap >= GAP, "R7 quiet gap", min_gap, GAP);
      check(straddle == 0, "R8 no start inside frame", straddle, 0);
   endtask

   task automatic t_overlap(input int per_seq);
      bit got;
      overlap_mode = 1'b1;
      next_val = 12'h123;
      run_en = 1'b1;
      wait_vld(2000, got);
      check(got && result == 12'h000, "R9 previous result first", result, 0);
      wait_busy_low();
      next_val = 12'hFFF;
      wait_vld(2000, got);
      check(got && result == 12'h123, "R9 previous result second", result, 12'h123);
      wait_busy_low();
      wait_vld(2000, got);
      run_en = 1'b0;
      check(got && result == 12'hFFF, "R9 previous result third", result, 12'hFFF);
      check(rises_at_vld == 16, "R4 pulses overlapped", rises_at_vld, 16);
      check(overlap_rise > 0, "R9 readout during busy", overlap_rise, 1);
      check(period < per_seq, "R9 shorter cycle", period, per_seq);
      repeat (800) @(negedge clk);
      check(straddle == 0, "R8 no start inside frame overlapped", straddle, 0);
      check(min_gap >= GAP, "R7 quiet gap overlapped", min_gap, GAP);
   endtask

   task automatic t_timeout();
      bit got;
      int v0, t0, el;
      overlap_mode = 1'b0;
      stuck = 1'b1;
      v0 = vld_count;
      run_en = 1'b1;
      @(negedge clk);
      t0 = cyc;
      got = 0;
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk); #1;
         if (busy_timeout) begin got = 1; break; end
      end
      el = cyc - t0;
      check(got, "R10 timeout flag", got, 1);
      check(el >= TMO && el <= TMO + PULSE + 4, "R10 timeout delay", el, TMO + PULSE);
      check(vld_count == v0, "R10 no result on timeout", vld_count, v0);
      stuck = 1'b0;
      next_val = 12'h777;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk); #1;
         if (!conv_start_n) break;
      end
      @(negedge clk); #1;
      check(busy_timeout == 1'b0, "R10 flag clears at start", busy_timeout, 0);
      wait_vld(2000, got);
      run_en = 1'b0;
      check(got && result == 12'h777, "R10 recovery frame", result, 12'h777);
      repeat (300) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int per_seq;
      t_reset();
      t_sequential(per_seq);
      t_overlap(per_seq);
      t_timeout();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule